// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block turns one multi-register transfer instruction word and the current value of its base register into a series of single-word memory requests. For each register named in the instruction's 16-bit list it presents one request carrying the byte address and the register index, waits for the memory side to acknowledge it, and moves on. When the list is exhausted it reports the new base value for write-back and whether the status register is to be restored from its saved copy.

The four addressing forms are handled: incrementing or decrementing, with the step applied before or after each access. In every form the lowest-numbered register lands at the lowest address, so a decrementing transfer first computes the bottom of the block from the number of listed registers. Each request also says whether the register must be taken from the user bank rather than the bank of the current mode. The register file and its banks, and the memory itself, live outside this block.

A one-cycle `start_i` pulse launches a transfer while the block is idle; a start seen while busy is dropped. An empty list finishes at once with no memory traffic.

Top module: `block_xfer_seq`

## Requirements
- R1: After reset the block is idle: `busy_o`, `req_valid_o` and `done_o` are all low.
- R2: One request is issued per set bit of the list field (instruction bits 15:0, bit n names register n), in ascending register order, each address 4 above the previous one, so the lowest register goes to the lowest address.
- R3: With the up bit (bit 23) set, the first address is base when the pre bit (bit 24) is clear and base+4 when it is set; the final base value is base + 4*n for n listed registers.
- R4: With the up bit clear, the first address is base - 4*n + 4 when the pre bit is clear and base - 4*n when it is set; the final base value is base - 4*n. Address arithmetic wraps modulo 2^32.
- R5: A request holds its address, register index and qualifiers steady until `req_ack_i` is high at a clock edge; the next request (or `done_o`) appears in the following cycle.
- R6: `done_o` is high for exactly one cycle after the last acknowledged request; in that cycle `wb_en_o` equals the write-back bit (bit 21) and `wb_value_o` carries the final base value.
- R7: An accepted start with an empty list raises `done_o` in the next cycle with no request, and `wb_value_o` equals the base.
- R8: `restore_status_o` is high with `done_o` exactly when the qualifier bit (bit 22), the load bit (bit 20) and list bit 15 are all set; `req_user_bank_o` is high on each request when the qualifier bit is set and that restore case does not apply.
- R9: `req_load_o` equals the load bit (bit 20) of the accepted instruction on every request.
- R10: A start pulse while `busy_o` is high is ignored: the running sequence's addresses, registers and result are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Launch a transfer (accepted only when idle) |
| instr_i | input | 32 | Transfer instruction word |
| base_i | input | 32 | Current base register value |
| busy_o | output | 1 | A transfer is in progress (including the done cycle) |
| req_valid_o | output | 1 | Memory request present |
| req_addr_o | output | 32 | Byte address of the request |
| req_reg_o | output | 4 | Register index of the request |
| req_load_o | output | 1 | Request is a load (else a store) |
| req_user_bank_o | output | 1 | Use the user-bank register for this request |
| req_ack_i | input | 1 | Memory accepted the current request |
| done_o | output | 1 | One-cycle completion pulse |
| wb_en_o | output | 1 | Base write-back requested (valid with done) |
| wb_value_o | output | 32 | New base value (valid with done) |
| restore_status_o | output | 1 | Copy saved status into current status (valid with done) |

## Verification
The bench builds the block with its default parameters: a 32-bit address, a 16-entry list and a 4-byte step. The full 32-bit width brings the wrap of decrementing transfers below address zero within reach, and the 16-entry list lets the bench cover a full list, a single top register that triggers the status restore, and the empty list. The acknowledge line is stalled on alternate cycles so that request hold behaviour is exercised in every transfer.

// File: rtl/bts_pkg.sv
// Package: shared state type and instruction field positions for the
// block transfer address sequencer.
package bts_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } bts_state_e;

    localparam int BIT_PRE   = 24;
    localparam int BIT_UP    = 23;
    localparam int BIT_QUAL  = 22;
    localparam int BIT_WBACK = 21;
    localparam int BIT_LOAD  = 20;
endpackage

// File: rtl/bts_list_scan.sv
// Module: bts_list_scan
// Finds the lowest set bit of a register list and counts its set bits.
// Assumes: purely combinational; idx is 0 when the list is empty.
module bts_list_scan #(
    parameter int NREG  = 16,
    localparam int IDXW = $clog2(NREG),
    localparam int CNTW = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0] list_i,
    output logic [IDXW-1:0] idx_o,
    output logic [CNTW-1:0] count_o,
    output logic            last_o
);
    // Priority scan from the top so the lowest set bit wins.
    always_comb begin
        idx_o = '0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (list_i[i]) idx_o = IDXW'(i);
        end
    end

    // Population count of the list.
    always_comb begin
        count_o = '0;
        for (int i = 0; i < NREG; i++) begin
            count_o = count_o + CNTW'(list_i[i]);
        end
    end

    // True when at most one bit remains.
    assign last_o = (count_o <= CNTW'(1));
endmodule

// File: rtl/bts_addr_plan.sv
// Module: bts_addr_plan
// Computes the first access address and the final base value for the four
// addressing forms. Assumes: modular arithmetic in ADDR_W bits.
module bts_addr_plan #(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int CNTW      = $clog2(NREG + 1)
) (
    input  logic [ADDR_W-1:0] base_i,
    input  logic [CNTW-1:0]   count_i,
    input  logic              up_i,
    input  logic              pre_i,
    output logic [ADDR_W-1:0] first_o,
    output logic [ADDR_W-1:0] final_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    logic [ADDR_W-1:0] span;

    // Total bytes covered by the block.
    assign span = ADDR_W'(count_i) * STEP;

    // Select start and end by direction and step placement.
    always_comb begin
        if (up_i) begin
            final_o = base_i + span;
            first_o = pre_i ? base_i + STEP : base_i;
        end else begin
            final_o = base_i - span;
            first_o = pre_i ? base_i - span : base_i - span + STEP;
        end
    end
endmodule

// File: rtl/block_xfer_seq.sv
// Module: block_xfer_seq (top)
// Walks the register list of a block transfer instruction, issuing one word
// request per listed register (lowest register at lowest address), then
// reports the write-back value and status-restore flag with a done pulse.
// Assumes: start_i is honoured only when idle; the requester holds nothing.
module block_xfer_seq
    import bts_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int NREG       = 16,
    parameter int WORD_BYTES = 4,
    localparam int IDXW      = $clog2(NREG),
    localparam int CNTW      = $clog2(NREG + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [31:0]       instr_i,
    input  logic [ADDR_W-1:0] base_i,
    output logic              busy_o,
    output logic              req_valid_o,
    output logic [ADDR_W-1:0] req_addr_o,
    output logic [IDXW-1:0]   req_reg_o,
    output logic              req_load_o,
    output logic              req_user_bank_o,
    input  logic              req_ack_i,
    output logic              done_o,
    output logic              wb_en_o,
    output logic [ADDR_W-1:0] wb_value_o,
    output logic              restore_status_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

    bts_state_e        state_q;
    logic [NREG-1:0]   remain_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W-1:0] final_q;
    logic              load_q, user_q, restore_q, wb_q;

    logic [NREG-1:0]   new_list;
    logic [IDXW-1:0]   new_idx_unused, cur_idx;
    logic [CNTW-1:0]   new_count, cur_count_unused;
    logic              new_last_unused, cur_last;
    logic [ADDR_W-1:0] first_c, final_c;
    logic              restore_c;
    logic              accept;

    assign new_list  = instr_i[NREG-1:0];
    assign accept    = start_i && (state_q == ST_IDLE);
    assign restore_c = instr_i[BIT_QUAL] && instr_i[BIT_LOAD] && instr_i[NREG-1];

    bts_list_scan #(.NREG(NREG)) u_scan_new (
        .list_i (new_list),
        .idx_o  (new_idx_unused),
        .count_o(new_count),
        .last_o (new_last_unused)
    );

    bts_list_scan #(.NREG(NREG)) u_scan_cur (
        .list_i (remain_q),
        .idx_o  (cur_idx),
        .count_o(cur_count_unused),
        .last_o (cur_last)
    );

    bts_addr_plan #(.ADDR_W(ADDR_W), .NREG(NREG), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base_i (base_i),
        .count_i(new_count),
        .up_i   (instr_i[BIT_UP]),
        .pre_i  (instr_i[BIT_PRE]),
        .first_o(first_c),
        .final_o(final_c)
    );

    // Sequencer state, list, address and captured qualifiers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            remain_q  <= '0;
            addr_q    <= '0;
            final_q   <= '0;
            load_q    <= 1'b0;
            user_q    <= 1'b0;
            restore_q <= 1'b0;
            wb_q      <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: if (accept) begin
                    remain_q  <= new_list;
                    addr_q    <= first_c;
                    final_q   <= final_c;
                    load_q    <= instr_i[BIT_LOAD];
                    restore_q <= restore_c;
                    user_q    <= instr_i[BIT_QUAL] && !restore_c;
                    wb_q      <= instr_i[BIT_WBACK];
                    state_q   <= (new_list == '0) ? ST_DONE : ST_RUN;
                end
                ST_RUN: if (req_ack_i) begin
                    remain_q[cur_idx] <= 1'b0;
                    addr_q            <= addr_q + STEP;
                    if (cur_last) state_q <= ST_DONE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy_o           = (state_q != ST_IDLE);
    assign req_valid_o      = (state_q == ST_RUN);
    assign req_addr_o       = addr_q;
    assign req_reg_o        = cur_idx;
    assign req_load_o       = load_q;
    assign req_user_bank_o  = user_q;
    assign done_o           = (state_q == ST_DONE);
    assign wb_en_o          = wb_q;
    assign wb_value_o       = final_q;
    assign restore_status_o = restore_q && done_o;

    // R2: the presented register is still pending in the list.
    assert_req_listed_R2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid_o |-> remain_q[req_reg_o]);

    // R2: an accepted request with more pending moves the address up one word.
    assert_addr_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && req_ack_i && !cur_last) |=> (req_valid_o && req_addr_o == $past(req_addr_o) + STEP));

    // R5: an unacknowledged request is held.
    assert_req_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_o && !req_ack_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_reg_o)));

    // R6: done lasts one cycle.
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7: empty list completes next cycle without a request.
    assert_empty_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && new_list == '0) |=> (done_o && !req_valid_o));

    // R10: a start while busy leaves the captured result untouched.
    assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o && start_i) |=> ($stable(final_q) && $stable(wb_q) && $stable(restore_q)));
endmodule

// File: tb/block_xfer_seq_tb_top.sv
// Scoreboard bench: the driver pushes expected requests into a queue, the
// monitor pops and compares as the design issues them.
module block_xfer_seq_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [31:0] base_i = '0;
    logic        busy_o, req_valid_o, req_load_o, req_user_bank_o;
    logic [31:0] req_addr_o;
    logic [3:0]  req_reg_o;
    logic        req_ack_i = 1'b0;
    logic        done_o, wb_en_o, restore_status_o;
    logic [31:0] wb_value_o;

    int checks = 0;
    int fails  = 0;
    int dones  = 0;

    logic [35:0] exp_q[$];
    logic [31:0] exp_wb;
    logic        exp_wben, exp_restore, exp_user, exp_load;
    logic        stall = 1'b0;

    always #2 clk = ~clk;

    block_xfer_seq dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .instr_i(instr_i), .base_i(base_i),
        .busy_o(busy_o), .req_valid_o(req_valid_o), .req_addr_o(req_addr_o),
        .req_reg_o(req_reg_o), .req_load_o(req_load_o), .req_user_bank_o(req_user_bank_o),
        .req_ack_i(req_ack_i), .done_o(done_o), .wb_en_o(wb_en_o),
        .wb_value_o(wb_value_o), .restore_status_o(restore_status_o)
    );

    task automatic chk(input bit ok, input string req, input logic [35:0] act, input logic [35:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: compare requests, ack on alternate cycles, check completion.
    always @(negedge clk) begin
        if (rst_n) begin
            req_ack_i <= 1'b0;
            if (req_valid_o) begin
                stall <= ~stall;
                if (!stall) begin
                    if (exp_q.size() == 0) begin
                        chk(1'b0, "R2 extra request", {req_reg_o, req_addr_o}, '0);
                    end else begin
                        chk({req_reg_o, req_addr_o} == exp_q[0], "R2/R3/R4/R5 request",
                            {req_reg_o, req_addr_o}, exp_q[0]);
                        void'(exp_q.pop_front());
                    end
                    chk(req_load_o == exp_load, "R9 load flag", 36'(req_load_o), 36'(exp_load));
                    chk(req_user_bank_o == exp_user, "R8 user bank", 36'(req_user_bank_o), 36'(exp_user));
                    req_ack_i <= 1'b1;
                end
            end
            if (done_o) begin
                chk(exp_q.size() == 0, "R6 all requests issued", 36'(exp_q.size()), 36'd0);
                chk(wb_value_o == exp_wb, "R6 write-back value", 36'(wb_value_o), 36'(exp_wb));
                chk(wb_en_o == exp_wben, "R6 write-back enable", 36'(wb_en_o), 36'(exp_wben));
                chk(restore_status_o == exp_restore, "R8 restore status",
                    36'(restore_status_o), 36'(exp_restore));
                dones++;
            end
        end
    end

    // Driver: build expectations from the requirements, then launch.
    task automatic run(input logic [31:0] ins, input logic [31:0] base, input bit poke);
        int n = 0;
        logic [31:0] a;
        bit restore;
        int target;
        for (int r = 0; r < 16; r++) if (ins[r]) n++;
        if (ins[23]) begin
            exp_wb = base + 32'(4 * n);
            a = ins[24] ? base + 32'd4 : base;
        end else begin
            exp_wb = base - 32'(4 * n);
            a = ins[24] ? base - 32'(4 * n) : base - 32'(4 * n) + 32'd4;
        end
        for (int r = 0; r < 16; r++) begin
            if (ins[r]) begin
                exp_q.push_back({4'(r), a});
                a = a + 32'd4;
            end
        end
        restore     = ins[22] && ins[20] && ins[15];
        exp_restore = restore;
        exp_user    = ins[22] && !restore;
        exp_load    = ins[20];
        exp_wben    = ins[21];
        target      = dones + 1;
        @(negedge clk);
        instr_i = ins;
        base_i  = base;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            // R10: a second start mid-sequence must be dropped.
            @(negedge clk);
            instr_i = 32'h01F0_0F0F;
            base_i  = 32'hDEAD_0000;
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        while (dones < target) @(negedge clk);
        @(negedge clk);
        chk(!busy_o, "R6 back to idle", 36'(busy_o), 36'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!busy_o && !req_valid_o && !done_o, "R1 reset state",
            {33'd0, busy_o, req_valid_o, done_o}, 36'd0);
        rst_n = 1'b1;
        // R3: up, post, store, write-back.
        run(32'h00A2_0085, 32'h0000_1000, 1'b0);
        // R3: up, pre, load.
        run(32'h01B0_1234, 32'h0000_2000, 1'b0);
        // R4: down, post, store, with wrap below zero.
        run(32'h0020_000F, 32'h0000_0008, 1'b0);
        // R4: down, pre, full list, write-back.
        run(32'h0120_FFFF, 32'h8000_0000, 1'b0);
        // R8: qualifier with load and R15 -> restore status.
        run(32'h0170_8001, 32'h0000_3000, 1'b0);
        // R8: qualifier on a store -> user bank.
        run(32'h00C0_6100, 32'h0000_4000, 1'b0);
        // R7: empty list.
        run(32'h00A0_0000, 32'h0000_5000, 1'b0);
        // R10: start while busy ignored.
        run(32'h0090_00F0, 32'h0000_6000, 1'b1);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule